// File: doc/BRIEF.md
# Audio InfoFrame Packet Builder

This block assembles the audio InfoFrame that a display transmitter sends to describe its audio stream. Configuration fields (coding type, channel count, sample-frequency code, sample-size code, speaker allocation, downmix inhibit and level-shift value) are latched on a one-cycle start pulse. The block packs them into fixed positions of a ten-byte payload and computes the packet checksum in hardware.

The finished packet leaves as a byte stream with a valid/ready handshake. The stream carries 14 bytes in this order: type, version, length, checksum, then payload bytes 1 to 10. A last flag marks the final byte, and a one-cycle done pulse follows it. A downstream framer can pull the bytes at whatever rate suits it. A start pulse that arrives while a packet is still in flight is dropped.

Top module: `aud_infoframe_tx`

## Requirements
- R1: During reset and after it, before any start pulse, `out_valid`, `out_last` and `done` are low.
- R2: A packet is exactly 14 bytes in this order: 0x84, 0x01, 0x0A, the checksum, then payload bytes 1 to 10. `out_last` is high only on the 14th byte.
- R3: Payload byte 1 carries the coding type in bits 7:4 and a zero in bit 3. Bits 2:0 carry the low three bits of the channel count minus one.
- R4: Payload byte 2 equals the 3-bit sample-frequency code shifted left by two, ORed with the 2-bit sample-size code. Bits 7:5 are zero.
- R5: Payload byte 3 and payload bytes 6 to 10 are always 0x00.
- R6: Payload byte 4 equals the 8-bit channel-allocation input unchanged.
- R7: Payload byte 5 has downmix inhibit in bit 7 and the 4-bit level-shift value in bits 6:3. Bits 2:0 are zero.
- R8: The checksum byte makes the sum of all 14 bytes equal to zero modulo 256.
- R9: A byte advances only on a cycle where `out_valid` and `out_ready` are both high. While `out_ready` is low, `out_data` and `out_last` hold.
- R10: In the cycle after the last byte's handshake, `done` is high for exactly one cycle and `out_valid` is low.
- R11: The configuration is taken on the start pulse. Changing the configuration inputs while a packet is being sent does not alter its bytes.
- R12: A start pulse during a packet is ignored. The packet runs to its end unchanged, and no second packet follows it.
- R13: With `out_ready` held high, the 14 bytes go out on 14 consecutive cycles, with no stall at the checksum byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | One-cycle request to build and send a packet |
| cfg_coding | input | 4 | Audio coding type |
| cfg_chans | input | 4 | Channel count, 1 to 8 |
| cfg_fs | input | 3 | Sample-frequency code |
| cfg_ss | input | 2 | Sample-size code |
| cfg_alloc | input | 8 | Speaker/channel allocation code |
| cfg_dm_inh | input | 1 | Downmix inhibit flag |
| cfg_lsv | input | 4 | Level-shift value |
| out_ready | input | 1 | Sink accepts the current byte |
| out_data | output | 8 | Current packet byte (zero when idle) |
| out_valid | output | 1 | `out_data` holds a packet byte |
| out_last | output | 1 | Current byte is the final byte of the packet |
| done | output | 1 | One-cycle pulse after the final byte is accepted |

## Verification
Any error in the byte counter shows at the ports on the next handshake. It appears as a misplaced header or payload byte, a `last` flag on the wrong beat, or a packet that is not 14 bytes long. A stale or wrongly timed checksum register makes the running sum of the packet non-zero, and this shows by the final beat. A capture enable that fires during a packet either restarts the stream, which shows as a 0x84 beat in mid-packet, or changes payload bytes in the same packet. The checks compare every byte at the moment it is accepted, so a fault is seen in the cycle it first reaches the stream.

// File: rtl/aif_pkg.sv
package aif_pkg;

  typedef struct packed {
    logic [3:0] coding;
    logic [3:0] chans;
    logic [2:0] fs;
    logic [1:0] ss;
    logic [7:0] alloc;
    logic       dm_inh;
    logic [3:0] lsv;
  } aif_cfg_t;

  // Number of payload bytes that carry fields; the rest are zero.
  localparam int unsigned AIF_FIELD_BYTES = 5;

  // Payload byte k (1-based) from a captured configuration.
  function automatic logic [7:0] aif_db(input aif_cfg_t c, input int unsigned k);
    logic [3:0] cm1;
    cm1 = c.chans - 4'd1;
    case (k)
      1:       return {c.coding, 1'b0, cm1[2:0]};
      2:       return {3'b000, c.fs, c.ss};
      4:       return c.alloc;
      5:       return {c.dm_inh, c.lsv, 3'b000};
      default: return 8'h00;
    endcase
  endfunction

  // Byte that brings an 8-bit running sum to zero.
  function automatic logic [7:0] aif_csum(input logic [7:0] sum);
    return 8'h00 - sum;
  endfunction

endpackage

// File: rtl/aif_payload_pack.sv
module aif_payload_pack
  import aif_pkg::*;
#(
  parameter int unsigned N_BYTES = 10
) (
  input  aif_cfg_t               cfg,
  output logic [N_BYTES*8-1:0]   payload
);

  for (genvar k = 0; k < N_BYTES; k++) begin : g_db
    if (k < AIF_FIELD_BYTES) begin : g_fld
      assign payload[k*8 +: 8] = aif_db(cfg, k + 1);
    end else begin : g_rsv
      assign payload[k*8 +: 8] = 8'h00;
    end
  end

endmodule

// File: rtl/aif_checksum.sv
module aif_checksum
  import aif_pkg::*;
#(
  parameter int unsigned N_BYTES = 10,
  parameter logic [7:0]  HDR0    = 8'h84,
  parameter logic [7:0]  HDR1    = 8'h01,
  parameter logic [7:0]  HDR2    = 8'h0A
) (
  input  logic [N_BYTES*8-1:0] payload,
  output logic [7:0]           csum
);

  logic [7:0] acc;

  always_comb begin
    acc = HDR0 + HDR1 + HDR2;
    for (int i = 0; i < N_BYTES; i++) begin
      acc = acc + payload[i*8 +: 8];
    end
    csum = aif_csum(acc);
  end

endmodule

// File: rtl/aif_seq.sv
module aif_seq #(
  parameter int unsigned TOTAL = 14,
  localparam int unsigned IDX_W = $clog2(TOTAL)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             out_ready,
  output logic             out_valid,
  output logic             out_last,
  output logic             done,
  output logic             cap_en,
  output logic             csum_load,
  output logic             hs,
  output logic [IDX_W-1:0] byte_idx
);

  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(TOTAL - 1);

  logic             busy_q;
  logic [IDX_W-1:0] idx_q;
  logic             done_q;
  logic             load_q;
  logic             fin;

  assign cap_en = start & ~busy_q;
  assign hs     = busy_q & out_ready;
  assign fin    = hs && (idx_q == LAST_IDX);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      idx_q  <= '0;
      done_q <= 1'b0;
      load_q <= 1'b0;
    end else begin
      done_q <= fin;
      load_q <= cap_en;
      if (cap_en) begin
        busy_q <= 1'b1;
        idx_q  <= '0;
      end else if (fin) begin
        busy_q <= 1'b0;
        idx_q  <= '0;
      end else if (hs) begin
        idx_q <= idx_q + 1'b1;
      end
    end
  end

  assign out_valid = busy_q;
  assign out_last  = busy_q && (idx_q == LAST_IDX);
  assign done      = done_q;
  assign csum_load = load_q;
  assign byte_idx  = idx_q;

endmodule

// File: rtl/aud_infoframe_tx.sv
module aud_infoframe_tx
  import aif_pkg::*;
#(
  parameter logic [7:0]  PKT_TYPE    = 8'h84,
  parameter logic [7:0]  PKT_VER     = 8'h01,
  parameter int unsigned PAYLOAD_LEN = 10
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic [3:0] cfg_coding,
  input  logic [3:0] cfg_chans,
  input  logic [2:0] cfg_fs,
  input  logic [1:0] cfg_ss,
  input  logic [7:0] cfg_alloc,
  input  logic       cfg_dm_inh,
  input  logic [3:0] cfg_lsv,
  input  logic       out_ready,
  output logic [7:0] out_data,
  output logic       out_valid,
  output logic       out_last,
  output logic       done
);

  localparam int unsigned HDR      = 3;
  localparam int unsigned CSUM_POS = HDR;
  localparam int unsigned TOTAL    = HDR + 1 + PAYLOAD_LEN;
  localparam int unsigned IDX_W    = $clog2(TOTAL);
  localparam logic [7:0]  LEN_BYTE = 8'(PAYLOAD_LEN);

  // Named internal events, visible to the bound checker.
  logic                     cap_en;
  logic                     csum_load;
  logic                     hs;
  logic [IDX_W-1:0]         byte_idx;
  logic [7:0]               csum_comb;
  logic [PAYLOAD_LEN*8-1:0] payload;

  aif_cfg_t   cfg_q;
  logic [7:0] csum_q;
  logic [7:0] data_mux;
  int         pidx;

  aif_seq #(.TOTAL(TOTAL)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .out_ready (out_ready),
    .out_valid (out_valid),
    .out_last  (out_last),
    .done      (done),
    .cap_en    (cap_en),
    .csum_load (csum_load),
    .hs        (hs),
    .byte_idx  (byte_idx)
  );

  aif_payload_pack #(.N_BYTES(PAYLOAD_LEN)) u_pack (
    .cfg     (cfg_q),
    .payload (payload)
  );

  aif_checksum #(
    .N_BYTES (PAYLOAD_LEN),
    .HDR0    (PKT_TYPE),
    .HDR1    (PKT_VER),
    .HDR2    (LEN_BYTE)
  ) u_csum (
    .payload (payload),
    .csum    (csum_comb)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q  <= '0;
      csum_q <= 8'h00;
    end else begin
      if (cap_en) begin
        cfg_q <= '{coding: cfg_coding, chans: cfg_chans, fs: cfg_fs, ss: cfg_ss,
                   alloc: cfg_alloc, dm_inh: cfg_dm_inh, lsv: cfg_lsv};
      end
      if (csum_load) begin
        csum_q <= csum_comb;
      end
    end
  end

  always_comb begin
    pidx     = int'(byte_idx) - int'(HDR + 1);
    data_mux = 8'h00;
    if (byte_idx == IDX_W'(0)) begin
      data_mux = PKT_TYPE;
    end else if (byte_idx == IDX_W'(1)) begin
      data_mux = PKT_VER;
    end else if (byte_idx == IDX_W'(2)) begin
      data_mux = LEN_BYTE;
    end else if (byte_idx == IDX_W'(CSUM_POS)) begin
      data_mux = csum_q;
    end else if (pidx >= 0 && pidx < int'(PAYLOAD_LEN)) begin
      data_mux = payload[pidx*8 +: 8];
    end
  end

  assign out_data = out_valid ? data_mux : 8'h00;

endmodule

// File: rtl/aud_infoframe_chk.sv
module aud_infoframe_chk #(
  parameter logic [7:0]  PKT_TYPE = 8'h84,
  parameter int unsigned TOTAL    = 14,
  localparam int unsigned CNT_W   = $clog2(TOTAL + 1)
) (
  input logic       clk,
  input logic       rst_n,
  input logic       out_ready,
  input logic       out_valid,
  input logic       out_last,
  input logic [7:0] out_data,
  input logic       done,
  input logic       cap_en,
  input logic       hs
);

  logic [7:0]       run_sum;
  logic [CNT_W-1:0] hs_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_sum <= 8'h00;
      hs_cnt  <= '0;
    end else if (hs) begin
      if (out_last) begin
        run_sum <= 8'h00;
        hs_cnt  <= '0;
      end else begin
        run_sum <= run_sum + out_data;
        hs_cnt  <= hs_cnt + 1'b1;
      end
    end
  end

  assert_quiet_after_reset_R1: assert property (@(posedge clk)
    $rose(rst_n) |-> (!out_valid && !out_last && !done));

  assert_last_needs_valid_R2: assert property (@(posedge clk) disable iff (!rst_n)
    out_last |-> out_valid);

  assert_first_byte_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> (out_data == PKT_TYPE));

  assert_beat_count_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (hs && out_last) |-> (hs_cnt == CNT_W'(TOTAL - 1)));

  assert_sum_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (hs && out_last) |-> (8'(run_sum + out_data) == 8'h00));

  assert_hold_on_stall_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_last)));

  assert_done_after_last_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready && out_last) |=> (done && !out_valid));

  assert_done_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_no_capture_in_flight_R12: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !cap_en);

  assert_no_gap_R13: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready && !out_last) |=> out_valid);

endmodule

bind aud_infoframe_tx aud_infoframe_chk #(.PKT_TYPE(PKT_TYPE), .TOTAL(TOTAL)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .out_ready (out_ready),
  .out_valid (out_valid),
  .out_last  (out_last),
  .out_data  (out_data),
  .done      (done),
  .cap_en    (cap_en),
  .hs        (hs)
);

// File: tb/aud_infoframe_tx_test.sv
`timescale 1ns/1ps
module aud_infoframe_tx_test;

  typedef struct packed {
    logic [3:0] coding;
    logic [3:0] chans;
    logic [2:0] fs;
    logic [1:0] ss;
    logic [7:0] alloc;
    logic       dm;
    logic [3:0] lsv;
    logic [1:0] rmode;   // 0 always ready, 1 every other cycle, 2 one in three
    logic [7:0] b1;
    logic [7:0] b2;
    logic [7:0] b4;
    logic [7:0] b5;
  } vec_t;

  localparam int NVEC = 4;
  localparam vec_t VECS [NVEC] = '{
    '{coding:4'h1, chans:4'd2, fs:3'd3, ss:2'd1, alloc:8'h00, dm:1'b0, lsv:4'h0, rmode:2'd0,
      b1:8'h11, b2:8'h0D, b4:8'h00, b5:8'h00},
    '{coding:4'hF, chans:4'd8, fs:3'd7, ss:2'd3, alloc:8'h1F, dm:1'b1, lsv:4'hF, rmode:2'd1,
      b1:8'hF7, b2:8'h1F, b4:8'h1F, b5:8'hF8},
    '{coding:4'h0, chans:4'd1, fs:3'd0, ss:2'd0, alloc:8'hFF, dm:1'b1, lsv:4'h5, rmode:2'd2,
      b1:8'h00, b2:8'h00, b4:8'hFF, b5:8'hA8},
    '{coding:4'hA, chans:4'd6, fs:3'd2, ss:2'd2, alloc:8'h13, dm:1'b0, lsv:4'hA, rmode:2'd1,
      b1:8'hA5, b2:8'h0A, b4:8'h13, b5:8'h50}
  };

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start = 1'b0;
  logic [3:0] cfg_coding = '0;
  logic [3:0] cfg_chans = '0;
  logic [2:0] cfg_fs = '0;
  logic [1:0] cfg_ss = '0;
  logic [7:0] cfg_alloc = '0;
  logic       cfg_dm_inh = 1'b0;
  logic [3:0] cfg_lsv = '0;
  logic       out_ready = 1'b0;
  logic [7:0] out_data;
  logic       out_valid;
  logic       out_last;
  logic       done;

  int tests = 0;
  int fails = 0;

  always #2.5 clk = ~clk;

  aud_infoframe_tx uut (
    .clk(clk), .rst_n(rst_n), .start(start),
    .cfg_coding(cfg_coding), .cfg_chans(cfg_chans), .cfg_fs(cfg_fs), .cfg_ss(cfg_ss),
    .cfg_alloc(cfg_alloc), .cfg_dm_inh(cfg_dm_inh), .cfg_lsv(cfg_lsv),
    .out_ready(out_ready), .out_data(out_data), .out_valid(out_valid),
    .out_last(out_last), .done(done)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic bit ready_at(input int mode, input int cyc);
    case (mode)
      1:       return (cyc % 2) == 0;
      2:       return (cyc % 3) == 2;
      default: return 1'b1;
    endcase
  endfunction

  function automatic string req_of(input int i);
    case (i)
      0, 1, 2: return "R2";
      3:       return "R8";
      4:       return "R3 R11";
      5:       return "R4 R11";
      7:       return "R6 R11";
      8:       return "R7 R11";
      default: return "R5";
    endcase
  endfunction

  // Send one packet; poke >= 0 pulses start at that collection cycle.
  task automatic run_packet(input vec_t v, input int poke);
    logic [7:0] exp_b [14];
    logic [7:0] got_b [14];
    bit         got_l [14];
    logic [7:0] sum;
    logic [7:0] held_d;
    bit         held_l;
    bit         stalled;
    bit         finished;
    int         n;
    int         cyc;

    exp_b[0] = 8'h84; exp_b[1] = 8'h01; exp_b[2] = 8'h0A;
    exp_b[4] = v.b1;  exp_b[5] = v.b2;  exp_b[6] = 8'h00;
    exp_b[7] = v.b4;  exp_b[8] = v.b5;
    for (int i = 9; i < 14; i++) exp_b[i] = 8'h00;
    sum = 8'h00;
    for (int i = 0; i < 14; i++) if (i != 3) sum = sum + exp_b[i];
    exp_b[3] = 8'h00 - sum;

    @(negedge clk);
    cfg_coding = v.coding; cfg_chans = v.chans; cfg_fs = v.fs; cfg_ss = v.ss;
    cfg_alloc = v.alloc; cfg_dm_inh = v.dm; cfg_lsv = v.lsv;
    start = 1'b1; out_ready = 1'b0;
    @(negedge clk);
    start = 1'b0;
    // R11: disturb the configuration inputs while the packet is in flight.
    cfg_coding = ~v.coding; cfg_chans = ~v.chans; cfg_fs = ~v.fs; cfg_ss = ~v.ss;
    cfg_alloc = ~v.alloc; cfg_dm_inh = ~v.dm; cfg_lsv = ~v.lsv;

    n = 0; cyc = 0; stalled = 1'b0; finished = 1'b0;
    held_d = 8'h00; held_l = 1'b0;
    while (!finished && cyc < 200) begin
      out_ready = ready_at(int'(v.rmode), cyc);
      start = (cyc == poke);
      #1;
      if (stalled) begin
        check(out_valid && out_data == held_d && out_last == held_l, "R9",
              "byte held during stall", int'(out_data), int'(held_d));
        stalled = 1'b0;
      end
      if (out_valid && n < 14) begin
        if (out_ready) begin
          got_b[n] = out_data;
          got_l[n] = out_last;
          n++;
          if (out_last) finished = 1'b1;
        end else begin
          held_d = out_data; held_l = out_last; stalled = 1'b1;
        end
      end
      cyc++;
      @(negedge clk);
      start = 1'b0;
    end

    out_ready = 1'b0;
    #1;
    check(n == 14, "R2", "packet length", n, 14);
    if (v.rmode == 2'd0)
      check(cyc == 14, "R13", "cycles for full packet", cyc, 14);
    check(done == 1'b1, "R10", "done after last", int'(done), 1);
    check(out_valid == 1'b0, "R10", "valid low after last", int'(out_valid), 0);
    sum = 8'h00;
    for (int i = 0; i < n; i++) begin
      check(got_b[i] == exp_b[i], req_of(i), $sformatf("byte %0d", i),
            int'(got_b[i]), int'(exp_b[i]));
      check(got_l[i] == (i == 13), "R2", $sformatf("last flag byte %0d", i),
            int'(got_l[i]), int'(i == 13));
      sum = sum + got_b[i];
    end
    check(sum == 8'h00, "R8", "byte sum", int'(sum), 0);
    @(negedge clk);
    #1;
    check(done == 1'b0, "R10", "done is one cycle", int'(done), 0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    tests++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    // R1: reset state.
    repeat (3) @(negedge clk);
    #1;
    check(!out_valid && !out_last && !done, "R1", "outputs in reset",
          int'({out_valid, out_last, done}), 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    #1;
    check(!out_valid && !out_last && !done && out_data == 8'h00, "R1",
          "outputs idle after reset", int'({out_valid, out_last, done}), 0);

    // Table-driven packets.
    for (int k = 0; k < NVEC; k++) begin
      run_packet(VECS[k], -1);
    end

    // R12: start pulse in the middle of a packet is ignored.
    run_packet(VECS[3], 5);
    run_packet(VECS[0], 7);
    out_ready = 1'b1;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      #1;
      check(!out_valid, "R12", "no packet after ignored start", int'(out_valid), 0);
    end
    out_ready = 1'b0;

    // Back-to-back packets after done.
    run_packet(VECS[1], -1);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule